// File: doc/BRIEF.md
# Boot ROM Overlay Address Decoder

This block turns the address, address strobe and read/write direction of a 68000-style asynchronous bus into active-high chip selects for a boot ROM, main RAM and an I/O region. Its job is to let a processor that fetches reset vectors from address zero start from ROM, then give low memory to RAM so software can rewrite the vectors.

A one-bit overlay flag is set by reset. While the flag is set and a read is strobed, the ROM select answers at every address and the RAM and I/O selects stay off. The first strobed write clears the flag. That write is already decoded with the normal map, so it lands in RAM or I/O. After the flag clears, a fixed 24-bit map applies until the next reset: RAM in the lower half, an 512 KiB ROM window high up, and a 64 KiB I/O page at the very top. The flag is visible on an output pin.

Top module: `boot_overlay_decoder`

## Requirements
- R1: While reset is held, and after it is released, the overlay output reads 1 until a qualified write is taken.
- R2: With the overlay set and a strobed read (strobe low, direction high), the ROM select is 1 and the RAM and I/O selects are 0 at every address.
- R3: A qualified write (strobe low, direction low) present at a rising clock edge after reset release clears the overlay. It stays 0 through any later reads and writes until the next reset.
- R4: Strobed reads, and a low direction line with the strobe high, leave the overlay set.
- R5: While a qualified write is presented, the selects follow the normal map even if the overlay is still set.
- R6: Normal map, 24-bit address: RAM for 0x000000–0x7FFFFF, ROM for 0xF00000–0xF7FFFF, I/O for 0xFF0000–0xFFFFFF. Every other address selects nothing.
- R7: With the strobe high, all three selects are 0, whatever the overlay state.
- R8: At most one select is 1 at any time.
- R9: The ROM select is the OR of the effective overlay term and the ROM window match, gated by the strobe.
- R10: Asserting reset sets the overlay at once, without a clock. The release passes through a two-stage synchronizer, and a write present during reset or during the release edge does not clear the overlay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that samples the overlay clear |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 24 | Bus address |
| as_n | input | 1 | Address strobe, active low |
| rw | input | 1 | Direction: 1 read, 0 write |
| cs_rom | output | 1 | ROM select, active high |
| cs_ram | output | 1 | RAM select, active high |
| cs_io | output | 1 | I/O select, active high |
| overlay | output | 1 | Current overlay flag |

## Verification
The upper address byte is swept through all 256 values, with a varied low half, under strobed reads while the overlay is set. This separates a ROM select that is truly forced from one that only matches its window. The same sweep is repeated with reads and then writes after the clear, and the selects are compared with the arithmetic range map. Hand-picked addresses on both sides of every region edge catch off-by-one comparisons. Strobe-high and read-only phases show that only a qualified write clears the flag. Writes placed inside the reset window and on the release edge show that the synchronizer holds the flag set.

// File: rtl/ovl_dec_pkg.sv
package ovl_dec_pkg;

  // Index of each decoded region.
  typedef enum logic [1:0] {
    REG_RAM = 2'd0,
    REG_ROM = 2'd1,
    REG_IO  = 2'd2
  } region_e;

  localparam int unsigned N_REGION = 3;

  typedef struct packed {
    logic rom;
    logic ram;
    logic io;
  } sel_t;

endpackage

// File: rtl/ovl_rst_sync.sv
module ovl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_q_n = chain_q[STAGES-1];

endmodule

// File: rtl/ovl_flag.sv
module ovl_flag (
  input  logic clk,
  input  logic rst_q_n,
  input  logic wr_qual,
  output logic flag_q
);

  logic flag_d;
  logic flag_en;

  // The flag can only drop; the enable fires on a qualified write.
  always_comb begin
    flag_en = wr_qual & flag_q;
    flag_d  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      flag_q <= 1'b1;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

endmodule

// File: rtl/ovl_window.sv
module ovl_window #(
  parameter int unsigned           ADDR_W = 24,
  parameter logic [ADDR_W-1:0]     BASE   = '0,
  parameter int unsigned           SPAN_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);

  generate
    if (SPAN_W >= ADDR_W) begin : g_all
      assign hit = 1'b1;
    end else begin : g_cmp
      localparam int unsigned TAG_W = ADDR_W - SPAN_W;
      logic [TAG_W-1:0] tag;
      assign tag = BASE[ADDR_W-1:SPAN_W];
      assign hit = (addr[ADDR_W-1:SPAN_W] == tag);
    end
  endgenerate

endmodule

// File: rtl/ovl_select.sv
module ovl_select
  import ovl_dec_pkg::*;
(
  input  logic                 as_n,
  input  logic                 flag_q,
  input  logic                 wr_qual,
  input  logic [N_REGION-1:0]  hit,
  output sel_t                 sel
);

  logic strobe;
  logic ovl_eff;

  always_comb begin
    strobe  = ~as_n;
    // A qualified write is decoded with the normal map.
    ovl_eff = flag_q & ~wr_qual;
    sel.rom = strobe & (ovl_eff | hit[REG_ROM]);
    sel.ram = strobe & ~ovl_eff & hit[REG_RAM];
    sel.io  = strobe & ~ovl_eff & hit[REG_IO];
  end

endmodule

// File: rtl/boot_overlay_decoder.sv
module boot_overlay_decoder
  import ovl_dec_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 24,
  parameter logic [ADDR_W-1:0] RAM_BASE   = 24'h000000,
  parameter int unsigned       RAM_SPAN_W = 23,
  parameter logic [ADDR_W-1:0] ROM_BASE   = 24'hF00000,
  parameter int unsigned       ROM_SPAN_W = 19,
  parameter logic [ADDR_W-1:0] IO_BASE    = 24'hFF0000,
  parameter int unsigned       IO_SPAN_W  = 16,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              as_n,
  input  logic              rw,
  output logic              cs_rom,
  output logic              cs_ram,
  output logic              cs_io,
  output logic              overlay
);

  localparam logic [ADDR_W-1:0] BASES [N_REGION] = '{RAM_BASE, ROM_BASE, IO_BASE};
  localparam int unsigned       SPANS [N_REGION] = '{RAM_SPAN_W, ROM_SPAN_W, IO_SPAN_W};

  logic                rst_q_n;
  logic                wr_qual;
  logic                flag_q;
  logic [N_REGION-1:0] hit;
  sel_t                sel;

  assign wr_qual = ~as_n & ~rw;

  ovl_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  ovl_flag u_flag (
    .clk     (clk),
    .rst_q_n (rst_q_n),
    .wr_qual (wr_qual),
    .flag_q  (flag_q)
  );

  generate
    for (genvar g = 0; g < N_REGION; g++) begin : g_win
      ovl_window #(
        .ADDR_W (ADDR_W),
        .BASE   (BASES[g]),
        .SPAN_W (SPANS[g])
      ) u_win (
        .addr (addr),
        .hit  (hit[g])
      );
    end
  endgenerate

  ovl_select u_sel (
    .as_n    (as_n),
    .flag_q  (flag_q),
    .wr_qual (wr_qual),
    .hit     (hit),
    .sel     (sel)
  );

  assign cs_rom  = sel.rom;
  assign cs_ram  = sel.ram;
  assign cs_io   = sel.io;
  assign overlay = flag_q;

endmodule

// File: rtl/overlay_decoder_chk.sv
module overlay_decoder_chk (
  input logic clk,
  input logic rst_q_n,
  input logic as_n,
  input logic rw,
  input logic cs_rom,
  input logic cs_ram,
  input logic cs_io,
  input logic overlay
);

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    as_n |-> !(cs_rom || cs_ram || cs_io));

  p_single_sel_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    $onehot0({cs_rom, cs_ram, cs_io}));

  p_forced_rom_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (overlay && !as_n && rw) |-> (cs_rom && !cs_ram && !cs_io));

  p_write_clears_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!as_n && !rw) |=> !overlay);

  p_stays_clear_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    !overlay |=> !overlay);

  p_reads_keep_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (overlay && !(!as_n && !rw)) |=> overlay);

endmodule

bind boot_overlay_decoder overlay_decoder_chk u_chk (
  .clk     (clk),
  .rst_q_n (rst_q_n),
  .as_n    (as_n),
  .rw      (rw),
  .cs_rom  (cs_rom),
  .cs_ram  (cs_ram),
  .cs_io   (cs_io),
  .overlay (overlay)
);

// File: tb/sim_boot_overlay_decoder.sv
module sim_boot_overlay_decoder;

  localparam time CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [23:0] addr;
  logic        as_n;
  logic        rw;
  logic        cs_rom, cs_ram, cs_io, overlay;

  int n_checks;
  int n_errors;
  logic exp_ovl;

  boot_overlay_decoder u0 (
    .clk (clk), .rst_n (rst_n), .addr (addr), .as_n (as_n), .rw (rw),
    .cs_rom (cs_rom), .cs_ram (cs_ram), .cs_io (cs_io), .overlay (overlay)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Expected {overlay, rom, ram, io} from the stated map.
  function automatic logic [3:0] expect_out(input logic [23:0] a, input logic s_n,
                                            input logic r, input logic ov);
    logic eff, rom, ram, io;
    eff = ov && !(!s_n && !r);
    ram = (a < 24'h800000);
    rom = (a >= 24'hF00000) && (a < 24'hF80000);
    io  = (a >= 24'hFF0000);
    if (s_n) return {ov, 3'b000};
    if (eff) return {ov, 3'b100};
    return {ov, rom, ram, io};
  endfunction

  task automatic check(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {overlay, cs_rom, cs_ram, cs_io};
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s addr=%h as_n=%b rw=%b actual={ovl,rom,ram,io}=%b expected=%b",
               req, addr, as_n, rw, act, exp);
    end
  endtask

  // One bus cycle: drive after a falling edge, check, let the rising edge pass.
  task automatic step(input string req, input logic [23:0] a, input logic s_n, input logic r);
    @(negedge clk);
    addr = a; as_n = s_n; rw = r;
    #1;
    check(req, expect_out(a, s_n, r, exp_ovl));
    if (!s_n && !r) exp_ovl = 1'b0;
  endtask

  function automatic logic [23:0] sweep_addr(input int hi);
    logic [15:0] lo;
    lo = 16'(hi * 257) ^ 16'h5a3c;
    return {8'(hi), lo};
  endfunction

  initial begin
    n_checks = 0; n_errors = 0;
    #(CLK_PERIOD * 200000);
    n_errors++;
    $display("FAIL watchdog: run did not finish actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [23:0] edges [12];
    rst_n = 1'b0; addr = 24'h000010; as_n = 1'b1; rw = 1'b1; exp_ovl = 1'b1;
    repeat (2) @(negedge clk);
    #1 check("R1 reset state", 4'b1000);
    // R10/R5: write during reset decodes normally but leaves flag set.
    as_n = 1'b0; rw = 1'b0;
    #1 check("R5 write in reset", 4'b1010);
    @(negedge clk);
    rst_n = 1'b1;                  // release; write still held over first sync edge
    @(negedge clk);
    as_n = 1'b1; rw = 1'b1;
    #1 check("R10 write during release ignored", 4'b1000);
    repeat (2) @(negedge clk);
    #1 check("R1 after release", 4'b1000);

    // R7/R4: strobe high with direction low never clears or selects.
    for (int i = 0; i < 16; i++) step("R7 strobe high", sweep_addr(i * 16), 1'b1, 1'b0);
    step("R4 overlay kept after unstrobed writes", 24'h000000, 1'b1, 1'b1);

    // R2/R9: forced ROM at every upper byte under reads.
    for (int i = 0; i < 256; i++) step("R2 forced ROM read", sweep_addr(i), 1'b0, 1'b1);
    step("R4 overlay kept after reads", 24'h000000, 1'b1, 1'b1);

    // R5/R3: first write goes to RAM, then flag clears.
    step("R5 clearing write to RAM", 24'h000400, 1'b0, 1'b0);
    step("R3 overlay cleared", 24'h000000, 1'b1, 1'b1);
    step("R6 vector area now RAM", 24'h000000, 1'b0, 1'b1);

    // R6/R8/R9: normal map sweeps, reads then writes.
    for (int i = 0; i < 256; i++) step("R6 read map", sweep_addr(i), 1'b0, 1'b1);
    for (int i = 0; i < 256; i++) step("R3 write map sticky", sweep_addr(i), 1'b0, 1'b0);
    edges = '{24'h7FFFFF, 24'h800000, 24'hEFFFFF, 24'hF00000, 24'hF7FFFF, 24'hF80000,
              24'hFEFFFF, 24'hFF0000, 24'hFFFFFF, 24'h000000, 24'hF40000, 24'hFF8000};
    foreach (edges[k]) step("R6 region edge", edges[k], 1'b0, 1'b1);
    step("R7 strobe high after clear", 24'h000000, 1'b1, 1'b0);

    // R10: asynchronous reset re-arms the overlay immediately.
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1 check("R10 async set", 4'b1000);
    exp_ovl = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    step("R2 forced ROM after re-reset", 24'h123456, 1'b0, 1'b1);
    step("R9 clearing write in ROM window", 24'hF00004, 1'b0, 1'b0);
    step("R3 cleared again", 24'h000000, 1'b0, 1'b1);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule